// File: doc/BRIEF.md
# Flag-Setting Integer Execution Unit

This block is the integer execution stage of a register-to-register pipeline. Each accepted operation takes a first operand from the register file and a second operand from the shift stage. It also takes the carry bit produced by the shift stage, the current condition flags and a 4-bit operation code. From these it produces a destination value, a register write strobe and the next condition flags. Memory traffic, condition evaluation and multiply/divide live elsewhere.

There are sixteen operations. The add and subtract family includes forward and reverse subtract, each with and without the incoming carry. The bitwise family includes a clear-bits operation. Four comparison operations only update the flags. Two transfer operations pass the second operand straight through or inverted. Every output is registered, so a result appears exactly one clock after its operation is presented. The adder can be built either as a behavioural sum or as an explicit ripple chain, chosen by a parameter.

Top module: `dp_alu`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge appears at the outputs after that edge with `out_valid` high. With `in_valid` low, `out_valid` and `rd_we` are 0 after the edge. Opcode encoding: 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN.
- R2: ADD gives A+B. ADC gives A+B+C. CMN computes A+B. Here C is `flags_in[1]`.
- R3: SUB gives A-B. SBC gives A-B-(1-C). CMP computes A-B.
- R4: RSB gives B-A. RSC gives B-A-(1-C).
- R5: AND gives A&B. ORR gives A|B. EOR gives A^B. BIC gives A&~B. TST computes A&B and TEQ computes A^B.
- R6: MOV gives B and MVN gives ~B. The value of A has no effect on either.
- R7: The compare opcodes (8 to 11) never raise `rd_we` and always update the flags, whatever `set_flags` is. Every other opcode raises `rd_we` when it is valid.
- R8: For a non-compare opcode with `set_flags` low, `flags_out` equals the `flags_in` that was presented with it.
- R9: When arithmetic updates the flags, the flag order is {N,Z,C,V} on bits 3..0. N is the result MSB and Z means the result is zero. C is the unsigned carry out, so for subtract forms C=1 means no borrow. V means signed overflow.
- R10: When a bitwise or transfer opcode updates the flags, N and Z follow the result, C takes `shift_c`, and V keeps `flags_in[0]`.
- R11: While `rst_n` is low, `out_valid`, `rd_we`, `result` and `flags_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| set_flags | input | 1 | Request a flag update on non-compare opcodes |
| op_a | input | WIDTH | First operand (register) |
| op_b | input | WIDTH | Second operand (from shift stage) |
| shift_c | input | 1 | Carry out of the shift stage |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Result registered this cycle |
| result | output | WIDTH | Computed value |
| rd_we | output | 1 | Destination write strobe |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The block holds no state from one operation to the next beyond its output register. A wrong operand swap, inversion or carry selection therefore shows up in `result` or `flags_out` on the very cycle after the faulty operation, and the per-clock comparison against a wide-integer model reports it there. Carry and overflow faults only show at sign and word boundaries, so the stimulus includes 0x7FFFFFFF/0x80000000 edges, zero-minus-one borrows and carry-in chains. A write-strobe or flag-gating fault shows as `rd_we` raised for a compare, or as a flag change with `set_flags` low, again one cycle after the operation.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
      OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
      OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } alu_op_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;

   function automatic logic is_compare(input alu_op_e o);
      return (o[3:2] == 2'b10);
   endfunction

   function automatic logic is_arith(input alu_op_e o);
      return (o inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
   endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   if (STYLE == 1) begin : g_ripple
      logic [WIDTH:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]   = x[i] ^ y[i] ^ c[i];
         assign c[i+1]   = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
      end
      assign cout = c[WIDTH];
      assign ovf  = c[WIDTH] ^ c[WIDTH-1];
   end else begin : g_behav
      logic [WIDTH:0] wide;
      assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
      assign sum  = wide[WIDTH-1:0];
      assign cout = wide[WIDTH];
      assign ovf  = (x[WIDTH-1] == y[WIDTH-1]) && (wide[WIDTH-1] != x[WIDTH-1]);
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (op)
         OP_AND, OP_TST: y = a & b;
         OP_EOR, OP_TEQ: y = a ^ b;
         OP_ORR:         y = a | b;
         OP_BIC:         y = a & ~b;
         OP_MOV:         y = b;
         OP_MVN:         y = ~b;
         default:        y = '0;
      endcase
   end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [3:0]       op,
   input  logic             set_flags,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             shift_c,
   input  logic [3:0]       flags_in,
   output logic             out_valid,
   output logic [WIDTH-1:0] result,
   output logic             rd_we,
   output logic [3:0]       flags_out
);
   if (WIDTH < 2) begin : g_bad_width
      $error("dp_alu: WIDTH must be at least 2");
   end
   if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
      $error("dp_alu: ADDER_STYLE must be 0 or 1");
   end

   localparam int MSB = WIDTH - 1;

   alu_op_e          opc;
   logic             arith, swap, inv, cin;
   logic [WIDTH-1:0] x, y, sum, lres, res;
   logic             cout, ovf;
   logic [3:0]       nzcv, next_flags;

   assign opc   = alu_op_e'(op);
   assign arith = is_arith(opc);
   assign swap  = (opc == OP_RSB) || (opc == OP_RSC);
   assign inv   = opc inside {OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP};

   always_comb begin
      unique case (opc)
         OP_SUB, OP_RSB, OP_CMP: cin = 1'b1;
         OP_ADC, OP_SBC, OP_RSC: cin = flags_in[FLAG_C];
         default:                cin = 1'b0;
      endcase
   end

   assign x = swap ? op_b : op_a;
   assign y = inv ? ~(swap ? op_a : op_b) : (swap ? op_a : op_b);

   alu_addsub #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_add (
      .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op(opc), .a(op_a), .b(op_b), .y(lres)
   );

   assign res = arith ? sum : lres;

   always_comb begin
      nzcv[FLAG_N] = res[MSB];
      nzcv[FLAG_Z] = (res == '0);
      nzcv[FLAG_C] = arith ? cout : shift_c;
      nzcv[FLAG_V] = arith ? ovf : flags_in[FLAG_V];
      next_flags   = (is_compare(opc) || set_flags) ? nzcv : flags_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         rd_we     <= 1'b0;
         result    <= '0;
         flags_out <= '0;
      end else begin
         out_valid <= in_valid;
         rd_we     <= in_valid && !is_compare(opc);
         if (in_valid) begin
            result    <= res;
            flags_out <= next_flags;
         end
      end
   end

   // R1: a valid operation yields a valid output one cycle later
   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R7: compares never write the destination
   assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op[3:2] == 2'b10) |=> !rd_we);

   // R8: no flag change without the set-flags request
   assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op[3:2] != 2'b10 && !set_flags) |=> flags_out == $past(flags_in));

   // R10: bitwise/transfer flag update keeps V and takes the shifter carry
   assert_logic_cv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && set_flags && !is_arith(alu_op_e'(op)))
      |=> (flags_out[FLAG_V] == $past(flags_in[FLAG_V])) && (flags_out[FLAG_C] == $past(shift_c)));

   // R9: Z flag agrees with the registered result whenever flags were recomputed
   assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (set_flags || op[3:2] == 2'b10)) |=> flags_out[FLAG_Z] == (result == '0));

   // R1: no write strobe without a valid output
   assert_we_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> out_valid);
endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        in_valid = 0;
   logic [3:0]  op = 0;
   logic        set_flags = 0;
   logic [31:0] op_a = 0, op_b = 0;
   logic        shift_c = 0;
   logic [3:0]  flags_in = 0;
   logic        out_valid, rd_we;
   logic [31:0] result;
   logic [3:0]  flags_out;

   int compared = 0, mismatched = 0;
   bit done = 0;

   // expected values for the operation in flight
   bit          pend = 0;
   logic        e_valid, e_we;
   logic [31:0] e_res;
   logic [3:0]  e_flags;
   string       e_tag;

   always #5 clk = ~clk;

   dp_alu dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .set_flags(set_flags),
               .op_a(op_a), .op_b(op_b), .shift_c(shift_c), .flags_in(flags_in),
               .out_valid(out_valid), .result(result), .rd_we(rd_we), .flags_out(flags_out));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // behavioural reference using wide integers
   task automatic model(input int o, input bit s, input logic [31:0] a, input logic [31:0] b,
                        input bit sc, input logic [3:0] f);
      longint ua = longint'({32'h0, a}), ub = longint'({32'h0, b});
      longint sa = longint'($signed(a)), sb = longint'($signed(b));
      longint c  = longint'(f[1]);
      longint u = 0, sv = 0;
      bit ar = 1, cmp = (o >= 8 && o <= 11);
      logic [31:0] r;
      bit nc, nv;
      case (o)
         4, 11: begin u = ua + ub;     sv = sa + sb;     e_tag = "R2"; end
         5:     begin u = ua + ub + c; sv = sa + sb + c; e_tag = "R2"; end
         2, 10: begin u = ua - ub;     sv = sa - sb;     e_tag = "R3"; end
         6:     begin u = ua - ub - (1 - c); sv = sa - sb - (1 - c); e_tag = "R3"; end
         3:     begin u = ub - ua;     sv = sb - sa;     e_tag = "R4"; end
         7:     begin u = ub - ua - (1 - c); sv = sb - sa - (1 - c); e_tag = "R4"; end
         default: ar = 0;
      endcase
      if (ar) begin
         r  = u[31:0];
         nc = (o == 4 || o == 5 || o == 11) ? (u > 64'sh0FFFFFFFF) : (u >= 0);
         nv = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end else begin
         case (o)
            0, 8:  begin r = a & b;  e_tag = "R5"; end
            1, 9:  begin r = a ^ b;  e_tag = "R5"; end
            12:    begin r = a | b;  e_tag = "R5"; end
            14:    begin r = a & ~b; e_tag = "R5"; end
            13:    begin r = b;      e_tag = "R6"; end
            default: begin r = ~b;   e_tag = "R6"; end
         endcase
         nc = sc;
         nv = f[0];
      end
      if (cmp) e_tag = {e_tag, "/R7"};
      e_valid = 1;
      e_we    = !cmp;
      e_res   = r;
      e_flags = (cmp || s) ? {r[31], r == 0, nc, nv} : f;
      if (!(cmp || s)) e_tag = {e_tag, "/R8"};
      else e_tag = {e_tag, ar ? "/R9" : "/R10"};
   endtask

   task automatic check_pending();
      if (pend) begin
         chk({e_tag, " valid R1"}, 64'(out_valid), 64'(e_valid));
         chk({e_tag, " we R7"},    64'(rd_we),     64'(e_we));
         if (e_valid) begin
            chk({e_tag, " result"}, 64'(result),    64'(e_res));
            chk({e_tag, " flags"},  64'(flags_out), 64'(e_flags));
         end
      end
   endtask

   task automatic step(input int o, input bit s, input logic [31:0] a, input logic [31:0] b,
                       input bit sc, input logic [3:0] f);
      @(negedge clk);
      check_pending();
      in_valid = 1; op = 4'(o); set_flags = s; op_a = a; op_b = b; shift_c = sc; flags_in = f;
      model(o, s, a, b, sc, f);
      pend = 1;
   endtask

   task automatic idle();
      @(negedge clk);
      check_pending();
      in_valid = 0; op_a = 32'hDEAD_BEEF;
      e_valid = 0; e_we = 0; e_tag = "idle R1";
      pend = 1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("reset R11 valid", 64'(out_valid), 0);
      chk("reset R11 we",    64'(rd_we), 0);
      chk("reset R11 result",64'(result), 0);
      chk("reset R11 flags", 64'(flags_out), 0);
      @(negedge clk); rst_n = 1;

      // R2 carry and overflow edges
      step(4, 1, 32'h7FFF_FFFF, 32'h1, 0, 4'h0);
      step(4, 1, 32'hFFFF_FFFF, 32'h1, 0, 4'h0);
      step(5, 1, 32'h1, 32'h2, 0, 4'h2);
      step(11, 0, 32'h8000_0000, 32'h8000_0000, 0, 4'h0);
      // R3 borrow semantics
      step(2, 1, 32'h0, 32'h1, 0, 4'h0);
      step(2, 1, 32'h5, 32'h5, 0, 4'h0);
      step(6, 1, 32'h5, 32'h3, 0, 4'h0);
      step(6, 1, 32'h8000_0000, 32'h0, 0, 4'h0);
      step(10, 0, 32'h8000_0000, 32'h1, 0, 4'hF);
      // R4 reverse
      step(3, 1, 32'h3, 32'h10, 0, 4'h0);
      step(7, 1, 32'h10, 32'h3, 1, 4'h0);
      step(7, 1, 32'h1, 32'h1, 0, 4'h2);
      // R5 logic with V preservation (R10)
      step(14, 1, 32'hFF00_FF00, 32'h0F0F_0F0F, 1, 4'h1);
      step(12, 1, 32'h0, 32'h0, 0, 4'h1);
      step(8, 0, 32'hF0F0_0000, 32'h0F0F_FFFF, 1, 4'h1);
      step(9, 0, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 4'h0);
      // R6 moves ignore A
      step(13, 1, 32'h1234_5678, 32'h0, 1, 4'h0);
      step(15, 1, 32'hFFFF_FFFF, 32'h0, 0, 4'h1);
      // R8 no update without set_flags
      step(2, 0, 32'h0, 32'h1, 0, 4'h5);
      step(15, 0, 32'h0, 32'h0, 1, 4'hA);
      idle();
      idle();
      // randomized mix
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] ra = $urandom, rb = $urandom;
         if (i % 7 == 0) ra = 32'h8000_0000 ^ (ra & 32'h3);
         if (i % 11 == 0) begin ra = 0; rb = 0; end
         if (i % 13 == 5) idle();
         step(int'($urandom_range(0, 15)), 1'($urandom), ra, rb, 1'($urandom), 4'($urandom));
      end
      idle();
      idle();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule